// File: doc/BRIEF.md
# DRAM Cycle Type Classifier

This block watches the control strobes of an asynchronous DRAM that has one row strobe, four column-strobe lanes, a write strobe and an output-enable strobe, all active low. It samples them with a fast clock and reports what kind of memory cycle is under way. It is meant to sit inside a behavioural memory model or a bus checker. Data, addresses and analogue timing limits are outside its scope. Only the order of the strobe edges matters.

Every pin passes through a synchroniser, and edges are found on the synchronised copies. Classification starts when the row strobe asserts. It is refined as column-strobe and write-strobe edges arrive. It is finished when the row strobe releases, and the result then stays on the outputs until the next row-strobe assertion.

Additional outputs:
- A sticky flag records that the part has entered test mode.
- A counter counts page continuations within one row cycle.
- A flag marks a refresh that was hidden behind a preceding access.
- A flag warns when the data-output state of a late write is undefined.

There is no data stream, so every pin is a plain level with no handshake.

Top module: `dram_cycle_classifier`

## Requirements
- R1: Each pin passes through SYNC_STAGES flip-flops, which reset to the released (high) level. After reset, cycle_code is 0 (idle), page_count is 0 and every flag is 0. With SYNC_STAGES=2, an output caused by a pin change moves on the third rising clock edge after that change.
- R2: A row-strobe assertion while at least one column-strobe lane is already low and the write strobe is high gives cycle_code 5, a refresh with column strobe before row strobe. It also clears test_mode.
- R3: A row-strobe assertion while a column-strobe lane is already low and the write strobe is also low gives cycle_code 7, test-mode entry, and sets test_mode. test_mode then stays 1 through ordinary access cycles until a code-5 or code-6 cycle clears it.
- R4: A row-strobe assertion with all column-strobe lanes high shows cycle_code 0 until the first column strobe. If the row strobe releases with no column-strobe assertion in that cycle, cycle_code becomes 6 (row-only refresh) and test_mode clears.
- R5: In a non-refresh cycle, an access starts when any lane asserts while all lanes were high. cycle_code becomes 1 (read) if the write strobe is high at that moment, or 2 (early write) if it is low.
- R6: During a read access (code 1), if the write strobe asserts while the output enable is high, cycle_code becomes 3 (write controlled by output enable) and out_undef stays 0.
- R7: During a read access with the output enable low, a write-strobe assertion at least ACC_CYC clocks after the access started gives cycle_code 4 (read-modify-write). An earlier assertion gives cycle_code 3 with out_undef 1. out_undef clears on the next access start or row-strobe assertion.
- R8: Each access start after the first one in the same row cycle adds one to page_count and is classified again under R5. page_count saturates at 2^PCNT_W-1 and returns to 0 on each row-strobe assertion.
- R9: In a code-5 or code-7 cycle, hidden_ref is 1 when the column strobe has stayed low without a break since an access of the previous row cycle, and 0 otherwise. hidden_ref holds until the next row-strobe assertion.
- R10: The following leave all outputs unchanged: column, write and output-enable activity while the row strobe is high, and any such activity during a code-5 or code-7 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | NCAS | Column-strobe lanes, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| cycle_code | output | 3 | Decoded cycle type, values as in R2 to R7 |
| test_mode | output | 1 | Sticky test-mode flag |
| page_count | output | PCNT_W | Page continuations in the current row cycle |
| hidden_ref | output | 1 | Current refresh was hidden behind an access |
| out_undef | output | 1 | Late write came too early; data-output state undefined |

## Verification
The bench builds the block with its defaults: NCAS=4, SYNC_STAGES=2, ACC_CYC=3 and PCNT_W=4. ACC_CYC=3 is short enough that a write strobe can be placed on either side of the access window within a few clocks, so both outcomes of R7 are tested. A 4-bit page counter is small enough to reach its saturation value with a short train of page accesses. The two-stage synchroniser fixes a known three-edge latency, and the bench probes that latency edge by edge.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_READ   = 3'd1,
    CYC_EWRITE = 3'd2,
    CYC_LWRITE = 3'd3,
    CYC_RMW    = 3'd4,
    CYC_CBR    = 3'd5,
    CYC_RONLY  = 3'd6,
    CYC_TEST   = 3'd7
  } cyc_e;
endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcc_edge.sv
module dcc_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] prev,
  output logic [W-1:0] on,
  output logic [W-1:0] off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign on  = lvl & ~prev;
  assign off = ~lvl & prev;
endmodule

// File: rtl/dcc_fsm.sv
module dcc_fsm
  import dcc_pkg::*;
#(
  parameter int ACC_CYC = 3,
  parameter int PCNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_act,
  input  logic              ras_on,
  input  logic              ras_off,
  input  logic              cas_any,
  input  logic              cas_prev,
  input  logic              cas_on,
  input  logic              we_act,
  input  logic              we_on,
  input  logic              oe_act,
  output cyc_e              code,
  output logic              test_mode,
  output logic [PCNT_W-1:0] page_cnt,
  output logic              hidden,
  output logic              undef
);
  localparam int          CW    = $clog2(ACC_CYC + 1);
  localparam logic [CW-1:0] CSAT = CW'(ACC_CYC);
  localparam logic [PCNT_W-1:0] PMAX = '1;

  logic          refc;
  logic          acc;
  logic          hold;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code      <= CYC_IDLE;
      test_mode <= 1'b0;
      page_cnt  <= '0;
      hidden    <= 1'b0;
      undef     <= 1'b0;
      refc      <= 1'b0;
      acc       <= 1'b0;
      hold      <= 1'b0;
      cnt       <= '0;
    end else begin
      if (!cas_any)                        hold <= 1'b0;
      else if (cas_on && ras_act && !refc) hold <= 1'b1;

      if (ras_on) begin
        page_cnt <= '0;
        undef    <= 1'b0;
        acc      <= 1'b0;
        cnt      <= '0;
        if (cas_prev) begin
          refc   <= 1'b1;
          hidden <= hold;
          if (we_act) begin
            code      <= CYC_TEST;
            test_mode <= 1'b1;
          end else begin
            code      <= CYC_CBR;
            test_mode <= 1'b0;
          end
        end else begin
          refc   <= 1'b0;
          hidden <= 1'b0;
          code   <= CYC_IDLE;
        end
      end else if (ras_act && !refc) begin
        if (cas_on) begin
          if (acc && page_cnt != PMAX) page_cnt <= page_cnt + PCNT_W'(1);
          acc   <= 1'b1;
          cnt   <= '0;
          undef <= 1'b0;
          code  <= we_act ? CYC_EWRITE : CYC_READ;
        end else begin
          if (cas_any && cnt != CSAT) cnt <= cnt + CW'(1);
          if (we_on && cas_any && acc && code == CYC_READ) begin
            if (!oe_act) begin
              code <= CYC_LWRITE;
            end else if (cnt == CSAT) begin
              code <= CYC_RMW;
            end else begin
              code  <= CYC_LWRITE;
              undef <= 1'b1;
            end
          end
        end
      end else if (ras_off && !refc && !acc) begin
        code      <= CYC_RONLY;
        test_mode <= 1'b0;
      end
    end
  end

  // R3: test mode is only entered by a test-entry cycle
  a_r3_test_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> code == CYC_TEST);

  // R4: row-only code appears only after a row-strobe release
  a_r4_ronly_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CYC_RONLY && !$stable(code)) |-> $past(ras_off));

  // R8: page counter either clears or steps by one
  a_r8_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page_cnt) |-> (page_cnt == '0 || page_cnt == PCNT_W'($past(page_cnt) + PCNT_W'(1))));

  // R9: hidden refresh only on a refresh-type code
  a_r9_hidden_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    hidden |-> (code == CYC_CBR || code == CYC_TEST));

  // R7: undefined-output warning only on a late write
  a_r7_undef_late: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> code == CYC_LWRITE);
endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
  import dcc_pkg::*;
#(
  parameter int NCAS        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ACC_CYC     = 3,
  parameter int PCNT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic [NCAS-1:0]   cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  output logic [2:0]        cycle_code,
  output logic              test_mode,
  output logic [PCNT_W-1:0] page_count,
  output logic              hidden_ref,
  output logic              out_undef
);
  localparam int NSIG = NCAS + 3;
  localparam int EW   = 3;

  logic [NSIG-1:0] pins_raw, pins_s;
  logic            ras_a, cas_a, we_a, oe_a;
  logic [EW-1:0]   lvl, prv, on, off;
  cyc_e            code;

  assign pins_raw = {oe_n, we_n, cas_n, ras_n};

  dcc_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL({NSIG{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  assign ras_a = ~pins_s[0];
  assign cas_a = ~&pins_s[NCAS:1];
  assign we_a  = ~pins_s[NCAS+1];
  assign oe_a  = ~pins_s[NCAS+2];

  assign lvl = {we_a, cas_a, ras_a};

  dcc_edge #(.W(EW)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .prev(prv), .on(on), .off(off)
  );

  dcc_fsm #(.ACC_CYC(ACC_CYC), .PCNT_W(PCNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ras_act(ras_a), .ras_on(on[0]), .ras_off(off[0]),
    .cas_any(cas_a), .cas_prev(prv[1]), .cas_on(on[1]),
    .we_act(we_a), .we_on(on[2]), .oe_act(oe_a),
    .code(code), .test_mode(test_mode), .page_cnt(page_count),
    .hidden(hidden_ref), .undef(out_undef)
  );

  assign cycle_code = code;
endmodule

// File: tb/test_dram_cycle_classifier.sv
module test_dram_cycle_classifier;
  localparam int NCAS = 4;
  localparam int ACC  = 3;
  localparam int PW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1;
  logic [NCAS-1:0] cas_n = '1;
  logic we_n = 1'b1;
  logic oe_n = 1'b1;
  logic [2:0] cycle_code;
  logic test_mode, hidden_ref, out_undef;
  logic [PW-1:0] page_count;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_cycle_classifier #(.NCAS(NCAS), .SYNC_STAGES(2), .ACC_CYC(ACC), .PCNT_W(PW))
    i_dram_cycle_classifier (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .cycle_code(cycle_code), .test_mode(test_mode), .page_count(page_count),
      .hidden_ref(hidden_ref), .out_undef(out_undef));

  // behavioural reference: pin history delayed by the synchroniser depth
  logic [3:0] hist[$];
  int  m_code, m_page, m_cnt;
  bit  m_test, m_hid, m_und, m_ref, m_acc, m_hold;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{4'b0, 4'b0, 4'b0, 4'b0};
      m_code = 0; m_page = 0; m_cnt = 0;
      m_test = 0; m_hid = 0; m_und = 0; m_ref = 0; m_acc = 0; m_hold = 0;
    end else begin
      logic [3:0] pv, cu;
      bit r_dn, r_up, c_dn, w_dn, hold_old;
      hist.push_back({~ras_n, ~&cas_n, ~we_n, ~oe_n});
      void'(hist.pop_front());
      pv = hist[0]; cu = hist[1];
      r_dn = cu[3] && !pv[3];
      r_up = !cu[3] && pv[3];
      c_dn = cu[2] && !pv[2];
      w_dn = cu[1] && !pv[1];
      hold_old = m_hold;
      if (!cu[2]) m_hold = 0;
      else if (c_dn && cu[3] && !m_ref) m_hold = 1;
      if (r_dn) begin
        m_page = 0; m_und = 0; m_acc = 0; m_cnt = 0;
        m_ref = pv[2];
        m_hid = pv[2] && hold_old;
        if (!pv[2]) m_code = 0;
        else begin
          m_code = cu[1] ? 7 : 5;
          m_test = cu[1];
        end
      end else if (cu[3] && !m_ref) begin
        if (c_dn) begin
          if (m_acc && m_page < (1 << PW) - 1) m_page++;
          m_acc = 1; m_cnt = 0; m_und = 0;
          m_code = cu[1] ? 2 : 1;
        end else begin
          int c_old;
          c_old = m_cnt;
          if (cu[2] && m_cnt < ACC) m_cnt++;
          if (w_dn && cu[2] && m_acc && m_code == 1) begin
            if (!cu[0]) m_code = 3;
            else if (c_old >= ACC) m_code = 4;
            else begin m_code = 3; m_und = 1; end
          end
        end
      end else if (r_up && !m_ref && !m_acc) begin
        m_code = 6; m_test = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_run++;
      if (int'(cycle_code) != m_code || test_mode != m_test || int'(page_count) != m_page ||
          hidden_ref != m_hid || out_undef != m_und) begin
        n_fail++;
        $display("FAIL R1 per-clock model: got code=%0d tm=%0d pg=%0d hid=%0d und=%0d exp code=%0d tm=%0d pg=%0d hid=%0d und=%0d",
                 cycle_code, test_mode, page_count, hidden_ref, out_undef,
                 m_code, m_test, m_page, m_hid, m_und);
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    w(3);
    rst_n = 1'b1;
    w(2);
    // R1 reset state
    chk("R1 reset code", cycle_code, 0);
    chk("R1 reset test", test_mode, 0);
    chk("R1 reset page", page_count, 0);

    // R5 read, with R1 latency probe
    ras_n = 0; w(5);
    chk("R4 idle before cas", cycle_code, 0);
    cas_n = 4'b1011; w(2);
    chk("R1 two edges no change", cycle_code, 0);
    w(1);
    chk("R5 read", cycle_code, 1);
    cas_n = '1; w(4); ras_n = 1; w(5);
    chk("R10 code held after release", cycle_code, 1);
    // R10 activity with row strobe high
    cas_n = 4'b0111; we_n = 0; w(4); we_n = 1; cas_n = '1; w(5);
    chk("R10 ignored while ras high", cycle_code, 1);

    // R5 early write
    we_n = 0; w(4); ras_n = 0; w(4); cas_n = 4'b1110; w(5);
    chk("R5 early write", cycle_code, 2);
    cas_n = '1; we_n = 1; w(4); ras_n = 1; w(5);

    // R6 OE-controlled write
    ras_n = 0; w(4); cas_n = 4'b1101; w(5); we_n = 0; w(5);
    chk("R6 oe write", cycle_code, 3);
    chk("R6 undef clear", out_undef, 0);
    cas_n = '1; we_n = 1; w(4); ras_n = 1; w(5);

    // R7 read-modify-write
    oe_n = 0; ras_n = 0; w(4); cas_n = 4'b0000; w(8); we_n = 0; w(5);
    chk("R7 rmw", cycle_code, 4);
    chk("R7 rmw undef", out_undef, 0);
    cas_n = '1; we_n = 1; w(4); ras_n = 1; w(5);

    // R7 too-early write
    ras_n = 0; w(4); cas_n = 4'b1110; w(1); we_n = 0; w(5);
    chk("R7 early late-write code", cycle_code, 3);
    chk("R7 undef set", out_undef, 1);
    cas_n = '1; we_n = 1; w(4); ras_n = 1; w(5);
    ras_n = 0; w(5);
    chk("R7 undef cleared by ras", out_undef, 0);
    ras_n = 1; w(5);
    oe_n = 1;

    // R4 row-only
    chk("R4 row-only", cycle_code, 6);

    // R2 CBR, R10 activity inside refresh
    cas_n = 4'b1110; w(4); ras_n = 0; w(5);
    chk("R2 cbr", cycle_code, 5);
    chk("R9 not hidden", hidden_ref, 0);
    cas_n = '1; w(4); cas_n = 4'b1110; we_n = 0; w(5);
    chk("R10 cbr unchanged", cycle_code, 5);
    chk("R10 cbr page", page_count, 0);
    we_n = 1; ras_n = 1; w(4); cas_n = '1; w(5);

    // R3 test entry and stickiness
    cas_n = 4'b0111; we_n = 0; w(4); ras_n = 0; w(5);
    chk("R3 test code", cycle_code, 7);
    chk("R3 test flag", test_mode, 1);
    ras_n = 1; w(4); cas_n = '1; we_n = 1; w(5);
    ras_n = 0; w(4); cas_n = 4'b1110; w(5); cas_n = '1; w(4); ras_n = 1; w(5);
    chk("R3 sticky over read", test_mode, 1);
    ras_n = 0; w(5); ras_n = 1; w(5);
    chk("R4 row-only clears test", test_mode, 0);
    cas_n = 4'b0111; we_n = 0; w(4); ras_n = 0; w(5); ras_n = 1; w(4); cas_n = '1; we_n = 1; w(5);
    chk("R3 test again", test_mode, 1);
    cas_n = 4'b1011; w(4); ras_n = 0; w(5); ras_n = 1; w(4); cas_n = '1; w(5);
    chk("R2 cbr clears test", test_mode, 0);

    // R8 page continuation and reclassification
    ras_n = 0; w(4);
    cas_n = 4'b1110; w(4); cas_n = '1; w(4);
    cas_n = 4'b1101; w(4); cas_n = '1; w(4);
    we_n = 0; w(4); cas_n = 4'b0111; w(5);
    chk("R8 page count", page_count, 2);
    chk("R8 reclassified", cycle_code, 2);
    cas_n = '1; we_n = 1; w(4); ras_n = 1; w(5);
    // R8 saturation
    ras_n = 0; w(4);
    for (int k = 0; k < 17; k++) begin
      cas_n = 4'b1110; w(4); cas_n = '1; w(4);
    end
    chk("R8 saturate", page_count, 15);
    ras_n = 1; w(5);
    ras_n = 0; w(5);
    chk("R8 clear on ras", page_count, 0);
    ras_n = 1; w(5);

    // R9 hidden refresh
    ras_n = 0; w(4); cas_n = 4'b1110; w(5); ras_n = 1; w(5); ras_n = 0; w(5);
    chk("R9 hidden code", cycle_code, 5);
    chk("R9 hidden flag", hidden_ref, 1);
    ras_n = 1; w(4); cas_n = '1; w(4); cas_n = 4'b1110; w(4); ras_n = 0; w(5);
    chk("R9 plain cbr", hidden_ref, 0);
    ras_n = 1; w(4); cas_n = '1; w(5);

    finish_run();
  end
endmodule